// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations for a core. It is direct-mapped. Each index holds one physical page number that all access types share. Each index also holds three separate virtual-page tags: one for data loads, one for data stores and one for instruction fetches. A lookup presents a virtual address and an access type. The lookup is combinational against registered state, and it hits only when the tag belonging to that access type names the requested page.

A refill port installs a mapping for one access type. During a refill, the tags of the other two types at that index are invalidated when they name a different page. They are kept when they name the same page, so all of them then see the newly written physical page. A flush input invalidates every tag.

The block does not walk page tables, check permissions or report faults. The surrounding logic refills it after a miss has been resolved.

Top module: `tlb_split_dm`

## Requirements
- R1: After reset, no lookup hits and `lkPaddr` is zero.
- R2: The index is the virtual page number (`lkVaddr >> PAGE_BITS`) modulo `ENTRIES`, and the tag is the full virtual page number. Two pages that share an index therefore evict each other.
- R3: Access type codes are 0 = load, 1 = store, 2 = fetch. A lookup hits only when the tag array of its own type holds the requested page. Code 3 never hits.
- R4: On a hit, `lkPaddr` is the stored physical page number followed by the low `PAGE_BITS` of `lkVaddr`. On a miss, `lkPaddr` is zero.
- R5: A refill writes the new page number only into the tag array of its own type. A tag of another type at that index that already equals the new page is left as it is.
- R6: A refill invalidates every other-type tag at its index that differs from the new page.
- R7: The physical page field is shared by the three types, so a refill changes the result of every type that still hits at that index.
- R8: A flush invalidates all tags from the next cycle on. A refill presented in the same cycle as a flush is discarded.
- R9: A refill with type code 3 changes nothing.
- R10: The invalid tag value is all ones. A lookup never hits on it, so the all-ones virtual page is never served.
- R11: A refill takes effect at the clock edge that samples it. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkVaddr | input | VA_BITS | Lookup virtual address |
| lkType | input | 2 | Lookup access type (0 load, 1 store, 2 fetch, 3 none) |
| lkHit | output | 1 | Lookup hit |
| lkPaddr | output | PA_BITS | Translated physical address, zero on a miss |
| rfValid | input | 1 | Refill strobe |
| rfVpn | input | VA_BITS-PAGE_BITS | Virtual page number to install |
| rfType | input | 2 | Access type of the refill |
| rfPpn | input | PA_BITS-PAGE_BITS | Physical page number to install |
| flush | input | 1 | Invalidate all tags |

## Verification
The bench builds the block with 4 entries, 4-bit pages, an 8-bit virtual address and a 10-bit physical address. That gives 16 virtual pages and 4 access type codes, so every refill is followed by a sweep over all 64 page and type combinations, which compares the full contents against a model kept in the bench. At this size, index aliasing between pages four apart, the all-ones page, clearing and sharing across types, and overwriting the shared physical page on a second pass all come up on every index. Flush, flush colliding with a refill, and the unused type code are swept the same way.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } accType_e;

  localparam int NUM_TYPES = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic       flushAll;
    logic       refillEn;
    logic [2:0] wrSel;     // one-hot: which type's tag takes the new page
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rfValid,
  input  logic [1:0] rfType,
  input  logic       flush,
  output tlbStrobe_t str
);

  accType_e rfKind;

  always_comb begin
    rfKind       = accType_e'(rfType);
    str.flushAll = flush;
    // flush wins over a colliding refill; code 3 is not a type
    str.refillEn = rfValid && !flush && (rfKind != ACC_NONE);
    str.wrSel    = '0;
    if (str.refillEn) begin
      unique case (rfKind)
        ACC_LOAD:  str.wrSel = 3'b001;
        ACC_STORE: str.wrSel = 3'b010;
        ACC_FETCH: str.wrSel = 3'b100;
        default:   str.wrSel = 3'b000;
      endcase
    end
  end

  // R5
  wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str.wrSel));

  // R8
  flush_blocks_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (str.wrSel == 3'b000));

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPNW    = 20,
  parameter int PPNW    = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  tlbStrobe_t      str,
  input  logic [VPNW-1:0] rfVpn,
  input  logic [PPNW-1:0] rfPpn,
  input  logic [VPNW-1:0] lkVpn,
  input  logic [1:0]      lkType,
  output logic            lkHit,
  output logic [PPNW-1:0] lkPpn
);

  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [VPNW-1:0] INVALID_TAG = '1;

  logic [IDXW-1:0] rfIdx;
  logic [IDXW-1:0] lkIdx;
  assign rfIdx = rfVpn[IDXW-1:0];
  assign lkIdx = lkVpn[IDXW-1:0];

  logic [NUM_TYPES-1:0][VPNW-1:0] lkTag;

  // One tag array per access type
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    logic [VPNW-1:0] tagQ [ENTRIES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) tagQ[e] <= INVALID_TAG;
      end else if (str.flushAll) begin
        for (int e = 0; e < ENTRIES; e++) tagQ[e] <= INVALID_TAG;
      end else if (str.refillEn) begin
        if (str.wrSel[t])
          tagQ[rfIdx] <= rfVpn;
        else if (tagQ[rfIdx] != rfVpn)
          tagQ[rfIdx] <= INVALID_TAG;
      end
    end

    assign lkTag[t] = tagQ[lkIdx];
  end

  // Shared physical page field
  logic [PPNW-1:0] ppnQ [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) ppnQ[e] <= '0;
    end else if (str.refillEn) begin
      ppnQ[rfIdx] <= rfPpn;
    end
  end

  logic [VPNW-1:0] selTag;

  always_comb begin
    unique case (accType_e'(lkType))
      ACC_LOAD:  selTag = lkTag[0];
      ACC_STORE: selTag = lkTag[1];
      ACC_FETCH: selTag = lkTag[2];
      default:   selTag = INVALID_TAG;
    endcase
    lkHit = (selTag == lkVpn) && (selTag != INVALID_TAG);
    lkPpn = lkHit ? ppnQ[lkIdx] : '0;
  end

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(str.flushAll) |-> !lkHit);

  // R10
  no_invalid_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkVpn != INVALID_TAG));

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPpn == '0));

endmodule

// File: rtl/tlb_split_dm.sv
module tlb_split_dm
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int PAGE_BITS = 12,
  parameter int VA_BITS   = 32,
  parameter int PA_BITS   = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [VA_BITS-1:0]        lkVaddr,
  input  logic [1:0]                lkType,
  output logic                      lkHit,
  output logic [PA_BITS-1:0]        lkPaddr,
  input  logic                      rfValid,
  input  logic [VA_BITS-PAGE_BITS-1:0] rfVpn,
  input  logic [1:0]                rfType,
  input  logic [PA_BITS-PAGE_BITS-1:0] rfPpn,
  input  logic                      flush
);

  localparam int VPNW = VA_BITS - PAGE_BITS;
  localparam int PPNW = PA_BITS - PAGE_BITS;

  tlbStrobe_t      str;
  logic [VPNW-1:0] lkVpn;
  logic [PPNW-1:0] lkPpn;

  assign lkVpn = lkVaddr[VA_BITS-1:PAGE_BITS];

  tlb_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rfValid(rfValid),
    .rfType (rfType),
    .flush  (flush),
    .str    (str)
  );

  tlb_datapath #(
    .ENTRIES(ENTRIES),
    .VPNW   (VPNW),
    .PPNW   (PPNW)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .str   (str),
    .rfVpn (rfVpn),
    .rfPpn (rfPpn),
    .lkVpn (lkVpn),
    .lkType(lkType),
    .lkHit (lkHit),
    .lkPpn (lkPpn)
  );

  assign lkPaddr = lkHit ? {lkPpn, lkVaddr[PAGE_BITS-1:0]} : '0;

  // R11
  refill_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rfValid && !flush && rfType != 2'd3 && rfVpn != '1)
      && lkVpn == $past(rfVpn) && lkType == $past(rfType))
    |-> (lkHit && lkPaddr[PA_BITS-1:PAGE_BITS] == $past(rfPpn)));

endmodule

// File: tb/sim_tlb_split_dm.sv
module sim_tlb_split_dm;

  localparam int ENTRIES = 4;
  localparam int PB      = 4;
  localparam int VA      = 8;
  localparam int PA      = 10;
  localparam int VPNW    = VA - PB;
  localparam int PPNW    = PA - PB;
  localparam int NPAGES  = 1 << VPNW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [VA-1:0]   lkVaddr = '0;
  logic [1:0]      lkType = '0;
  logic            lkHit;
  logic [PA-1:0]   lkPaddr;
  logic            rfValid = 1'b0;
  logic [VPNW-1:0] rfVpn = '0;
  logic [1:0]      rfType = '0;
  logic [PPNW-1:0] rfPpn = '0;
  logic            flush = 1'b0;

  always #2.5 clk = ~clk;

  tlb_split_dm #(.ENTRIES(ENTRIES), .PAGE_BITS(PB), .VA_BITS(VA), .PA_BITS(PA)) u0 (
    .clk(clk), .rstN(rstN), .lkVaddr(lkVaddr), .lkType(lkType), .lkHit(lkHit),
    .lkPaddr(lkPaddr), .rfValid(rfValid), .rfVpn(rfVpn), .rfType(rfType),
    .rfPpn(rfPpn), .flush(flush)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model of the cache contents
  int mTag [3][ENTRIES];
  int mPpn [ENTRIES];

  function automatic int expPaddr(int v, int t, int off);
    int idx = v % ENTRIES;
    if (t < 3 && v != NPAGES - 1 && mTag[t][idx] == v)
      return (mPpn[idx] << PB) | off;
    return -1;
  endfunction

  task automatic checkOne(string req, int v, int t, int off);
    int e = expPaddr(v, t, off);
    bit eHit = (e >= 0);
    int ePa = eHit ? e : 0;
    nChecks++;
    if (lkHit !== eHit || lkPaddr !== PA'(ePa)) begin
      nFails++;
      $display("FAIL %s page=%0d type=%0d hit=%0b paddr=%0h expected hit=%0b paddr=%0h",
               req, v, t, lkHit, lkPaddr, eHit, ePa);
    end
  endtask

  // Sweep every page and type code; label derived from the case
  task automatic sweep(string phase);
    for (int v = 0; v < NPAGES; v++) begin
      for (int t = 0; t < 4; t++) begin
        int off = (v + 3 * t) % (1 << PB);
        string req;
        @(negedge clk);
        lkVaddr = VA'((v << PB) | off);
        lkType  = 2'(t);
        #1;
        if (t == 3) req = "R3";
        else if (v == NPAGES - 1) req = "R10";
        else if (expPaddr(v, t, off) >= 0) req = "R4";
        else req = phase;
        checkOne(req, v, t, off);
      end
    end
  endtask

  // Present a refill and/or flush for one cycle; check the same-cycle lookup
  task automatic refill(bit vld, int v, int t, int p, bit fl);
    @(negedge clk);
    rfValid = vld; rfVpn = VPNW'(v); rfType = 2'(t); rfPpn = PPNW'(p); flush = fl;
    lkVaddr = VA'(v << PB); lkType = 2'(t);
    #1;
    checkOne("R11", v, t, 0);   // old contents before the edge
    @(negedge clk);
    rfValid = 1'b0; flush = 1'b0;
    if (fl) begin
      for (int a = 0; a < 3; a++) for (int e = 0; e < ENTRIES; e++) mTag[a][e] = NPAGES - 1;
    end else if (vld && t < 3) begin
      int idx = v % ENTRIES;
      for (int a = 0; a < 3; a++) if (mTag[a][idx] != v) mTag[a][idx] = NPAGES - 1; // R6
      mTag[t][idx] = v;   // R5
      mPpn[idx] = p;      // R7 shared field
    end
    #1;
    checkOne("R11", v, t, 0);   // new contents one cycle later
  endtask

  initial begin
    for (int a = 0; a < 3; a++) for (int e = 0; e < ENTRIES; e++) mTag[a][e] = NPAGES - 1;
    for (int e = 0; e < ENTRIES; e++) mPpn[e] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    sweep("R1");
    // Two passes: second overwrites shared pages (R7), aliasing pages evict (R2)
    for (int pass = 0; pass < 2; pass++)
      for (int t = 0; t < 3; t++)
        for (int v = 0; v < NPAGES; v++) begin
          refill(1'b1, v, t, (v * 7 + t * 3 + pass * 11) % (1 << PPNW), 1'b0);
          sweep((v % 2) ? "R2" : "R6");
        end
    // R8: plain flush
    refill(1'b0, 0, 0, 0, 1'b1);
    sweep("R8");
    // Refill colliding with flush is dropped (R8)
    refill(1'b1, 5, 1, 9, 1'b0);
    refill(1'b1, 6, 2, 13, 1'b1);
    sweep("R8");
    // Same page across types keeps all tags (R5, R7)
    refill(1'b1, 9, 0, 21, 1'b0);
    refill(1'b1, 9, 2, 33, 1'b0);
    refill(1'b1, 9, 1, 40, 1'b0);
    sweep("R5");
    // R9: type code 3 changes nothing
    refill(1'b1, 9, 3, 2, 1'b0);
    refill(1'b1, 13, 3, 7, 1'b0);
    sweep("R9");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule